// File: doc/BRIEF.md
# Lane Synchronization State Machine

This block decides whether a serial lane has locked to the incoming symbol stream. It takes one 10-bit code group per clock from a word aligner that has already found the symbol boundary. With each group comes a valid strobe and a flag that marks the group as an invalid code. The block asserts a single sync status bit. Downstream clock-compensation logic uses that bit as its enable.

While hunting, the block counts comma code groups and declares lock after a fixed number of them. While locked, it keeps a running error level. Each flagged group raises the level. Each unbroken run of good groups lowers it by one. Lock is dropped when the level reaches its limit. After that, acquisition starts again from nothing. Cycles with the valid strobe low are skipped entirely.

Top module: `lsync_top`

## Requirements
- R1: The comma is recognized in both running disparities, as the code group 10'b0011111010 or 10'b1100000101 (bit 9 written first). No other value counts as a comma.
- R2: While hunting, sync_ok rises on the clock edge that samples the fourth accepted comma, so it reads high in the cycle after that group is presented. Good groups that are not commas neither advance nor clear the comma count.
- R3: While hunting, a valid group with the error flag set returns the comma count to zero. Acquisition then needs four fresh commas.
- R4: While locked, each valid flagged group raises the error level by one. sync_ok falls on the edge that samples the group bringing the level to seventeen.
- R5: While locked, every run of sixteen consecutive valid good groups lowers the error level by one. The run count restarts at zero after each such decrement and on every flagged group.
- R6: The error level never goes below zero. Good runs while the level is zero leave exactly seventeen errors needed to lose lock.
- R7: Losing lock clears the error level and the comma count. Lock returns only after four new commas.
- R8: A cycle with grp_vld low changes no counter and no output, whatever grp_cg and grp_err carry.
- R9: While rst is high and in the cycle after it falls, sync_ok is low and every count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_vld | input | 1 | Code group on grp_cg is present this cycle |
| grp_cg | input | 10 | Aligned 10-bit code group |
| grp_err | input | 1 | Code group is an invalid code |
| sync_ok | output | 1 | Lane is synchronized (registered) |

## Verification
Every decision is taken on the rising edge that samples the deciding group. This holds for the fourth comma, the seventeenth net error and every sixteenth good group. A change of sync_ok is therefore due one edge after the group is driven, with no further pipeline stage. The bench drives each group on a falling edge and lets one rising edge pass. It then compares sync_ok with its model on the next falling edge, so every comparison lands in the cycle the result is due. The directed cases are chosen so that the expected edge of lock or loss falls on an exact group count. Neighbouring counts then show up as a mismatch.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  localparam int unsigned CG_W = 10;

  // Comma code group in each running disparity
  localparam logic [CG_W-1:0] COMMA_RDN = 10'b0011111010;
  localparam logic [CG_W-1:0] COMMA_RDP = 10'b1100000101;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lsync_state_e;

  function automatic logic is_comma(input logic [CG_W-1:0] cg);
    return (cg == COMMA_RDN) || (cg == COMMA_RDP);
  endfunction

endpackage

// File: rtl/lsync_comma_det.sv
module lsync_comma_det
  import lsync_pkg::*;
(
  input  logic [CG_W-1:0] cg,
  output logic            hit
);

  localparam int unsigned NPAT = 2;
  localparam logic [NPAT-1:0][CG_W-1:0] PATS = {COMMA_RDP, COMMA_RDN};

  logic [NPAT-1:0] match;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    assign match[p] = (cg == PATS[p]);
  end

  assign hit = |match;

endmodule

// File: rtl/lsync_acq_cnt.sv
module lsync_acq_cnt #(
  parameter int unsigned ACQ_COMMAS = 4,
  localparam int unsigned CW = $clog2(ACQ_COMMAS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hunt,
  input  logic          vld,
  input  logic          err,
  input  logic          comma,
  output logic          acq_done,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] C_LAST = CW'(ACQ_COMMAS - 1);

  logic [CW-1:0] cnt_q;

  assign acq_done = hunt && vld && !err && comma && (cnt_q == C_LAST);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !hunt) begin
      cnt_q <= '0;
    end else if (vld) begin
      if (err) begin
        cnt_q <= '0;
      end else if (comma) begin
        cnt_q <= acq_done ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsync_err_trk.sv
module lsync_err_trk #(
  parameter int unsigned LOSS_ERRS = 17,
  parameter int unsigned GOOD_RUN  = 16,
  localparam int unsigned EW = $clog2(LOSS_ERRS + 1),
  localparam int unsigned RW = $clog2(GOOD_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic          vld,
  input  logic          err,
  output logic          lose,
  output logic [EW-1:0] lvl_o
);

  localparam logic [EW-1:0] E_LAST = EW'(LOSS_ERRS - 1);
  localparam logic [RW-1:0] R_LAST = RW'(GOOD_RUN - 1);

  logic [EW-1:0] err_q;
  logic [RW-1:0] run_q;

  assign lose  = locked && vld && err && (err_q == E_LAST);
  assign lvl_o = err_q;

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      err_q <= '0;
      run_q <= '0;
    end else if (vld) begin
      if (err) begin
        run_q <= '0;
        err_q <= lose ? '0 : err_q + 1'b1;
      end else if (run_q == R_LAST) begin
        run_q <= '0;
        if (err_q != '0) err_q <= err_q - 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsync_top.sv
module lsync_top
  import lsync_pkg::*;
#(
  parameter int unsigned ACQ_COMMAS = 4,
  parameter int unsigned LOSS_ERRS  = 17,
  parameter int unsigned GOOD_RUN   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grp_vld,
  input  logic [CG_W-1:0] grp_cg,
  input  logic            grp_err,
  output logic            sync_ok
);

  localparam int unsigned CW = $clog2(ACQ_COMMAS + 1);
  localparam int unsigned EW = $clog2(LOSS_ERRS + 1);

  lsync_state_e  state_q, state_d;
  logic          comma_hit;
  logic          acq_done;
  logic          lose;
  logic [CW-1:0] comma_lvl;
  logic [EW-1:0] err_lvl;

  lsync_comma_det u_det (
    .cg  (grp_cg),
    .hit (comma_hit)
  );

  lsync_acq_cnt #(.ACQ_COMMAS(ACQ_COMMAS)) u_acq (
    .clk      (clk),
    .rst      (rst),
    .hunt     (state_q == ST_HUNT),
    .vld      (grp_vld),
    .err      (grp_err),
    .comma    (comma_hit),
    .acq_done (acq_done),
    .cnt_o    (comma_lvl)
  );

  lsync_err_trk #(.LOSS_ERRS(LOSS_ERRS), .GOOD_RUN(GOOD_RUN)) u_err (
    .clk    (clk),
    .rst    (rst),
    .locked (state_q == ST_LOCKED),
    .vld    (grp_vld),
    .err    (grp_err),
    .lose   (lose),
    .lvl_o  (err_lvl)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HUNT:   if (acq_done) state_d = ST_LOCKED;
      ST_LOCKED: if (lose)     state_d = ST_HUNT;
      default:                 state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_HUNT;
    else     state_q <= state_d;
  end

  assign sync_ok = (state_q == ST_LOCKED);

endmodule

// File: rtl/lsync_chk.sv
module lsync_chk
  import lsync_pkg::*;
#(
  parameter int unsigned ACQ_COMMAS = 4,
  parameter int unsigned LOSS_ERRS  = 17,
  localparam int unsigned CW = $clog2(ACQ_COMMAS + 1),
  localparam int unsigned EW = $clog2(LOSS_ERRS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            grp_vld,
  input logic [CG_W-1:0] grp_cg,
  input logic            grp_err,
  input logic            sync_ok,
  input logic [CW-1:0]   comma_lvl,
  input logic [EW-1:0]   err_lvl
);

  // R2: lock only follows an accepted comma
  a_r2_lock_on_comma: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_ok) |-> $past(grp_vld && !grp_err && is_comma(grp_cg)));

  // R4: lock only drops on a flagged group
  a_r4_loss_on_err: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_ok) |-> $past(grp_vld && grp_err));

  // R4: error level stays below the loss limit
  a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
    err_lvl < EW'(LOSS_ERRS));

  // R5: a good group never raises the error level
  a_r5_good_no_rise: assert property (@(posedge clk) disable iff (rst)
    (grp_vld && !grp_err && sync_ok) |=> (err_lvl <= $past(err_lvl)));

  // R7: no error level is held while hunting
  a_r7_hunt_level_zero: assert property (@(posedge clk) disable iff (rst)
    !sync_ok |-> (err_lvl == '0));

  // R8: idle cycles touch nothing
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !grp_vld |=> ($stable(sync_ok) && $stable(err_lvl) && $stable(comma_lvl)));

  // R3: a flagged group while hunting clears the comma count
  a_r3_err_clears: assert property (@(posedge clk) disable iff (rst)
    (!sync_ok && grp_vld && grp_err) |=> (comma_lvl == '0));

endmodule

bind lsync_top lsync_chk #(
  .ACQ_COMMAS (ACQ_COMMAS),
  .LOSS_ERRS  (LOSS_ERRS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .grp_vld   (grp_vld),
  .grp_cg    (grp_cg),
  .grp_err   (grp_err),
  .sync_ok   (sync_ok),
  .comma_lvl (comma_lvl),
  .err_lvl   (err_lvl)
);

// File: tb/lsync_top_tb_top.sv
`timescale 1ns/1ps
module lsync_top_tb_top;

  localparam logic [9:0] K_N  = 10'b0011111010;
  localparam logic [9:0] K_P  = 10'b1100000101;
  localparam logic [9:0] DATA = 10'b1010101010;

  logic       clk = 1'b0;
  logic       rst;
  logic       grp_vld;
  logic [9:0] grp_cg;
  logic       grp_err;
  logic       sync_ok;

  int checks   = 0;
  int failures = 0;

  // bench model state
  logic m_sync;
  int   m_comma;
  int   m_err;
  int   m_run;

  always #5 clk = ~clk;

  lsync_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .grp_vld (grp_vld),
    .grp_cg  (grp_cg),
    .grp_err (grp_err),
    .sync_ok (sync_ok)
  );

  function automatic logic model_comma(input logic [9:0] cg);
    return (cg == K_N) || (cg == K_P);
  endfunction

  task automatic model_reset();
    m_sync = 1'b0; m_comma = 0; m_err = 0; m_run = 0;
  endtask

  task automatic model_step(input logic v, input logic [9:0] cg, input logic e);
    if (!v) return;
    if (!m_sync) begin
      if (e) m_comma = 0;
      else if (model_comma(cg)) begin
        m_comma++;
        if (m_comma == 4) begin m_sync = 1'b1; m_comma = 0; m_err = 0; m_run = 0; end
      end
    end else begin
      if (e) begin
        m_run = 0;
        m_err++;
        if (m_err == 17) begin m_sync = 1'b0; m_err = 0; m_comma = 0; end
      end else begin
        m_run++;
        if (m_run == 16) begin
          m_run = 0;
          if (m_err > 0) m_err--;
        end
      end
    end
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s sync_ok actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at falling edge, sample result at next falling edge
  task automatic step(input logic v, input logic [9:0] cg, input logic e, input string tag);
    grp_vld = v; grp_cg = cg; grp_err = e;
    @(posedge clk);
    model_step(v, cg, e);
    @(negedge clk);
    check(sync_ok, m_sync, tag);
  endtask

  task automatic commas(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, (i % 2) ? K_P : K_N, 1'b0, tag);
  endtask

  task automatic errs(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, DATA, 1'b1, tag);
  endtask

  task automatic goods(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, DATA, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C0DE));
    model_reset();
    rst = 1'b1; grp_vld = 1'b0; grp_cg = '0; grp_err = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_ok, 1'b0, "R9 during reset");
    rst = 1'b0;
    @(negedge clk);
    check(sync_ok, 1'b0, "R9 after reset");

    // R1/R2: mixed disparities with data in between
    step(1'b1, K_P, 1'b0, "R1");
    goods(2, "R2 data between commas");
    step(1'b1, K_N, 1'b0, "R1");
    step(1'b1, K_P, 1'b0, "R1");
    check(sync_ok, 1'b0, "R2 three commas");
    // R3: error clears comma count
    errs(1, "R3");
    commas(3, "R3");
    check(sync_ok, 1'b0, "R3 count cleared by error");
    step(1'b1, K_N, 1'b0, "R2");
    check(sync_ok, 1'b1, "R2 fourth comma locks");

    // R4: seventeen errors lose lock
    errs(16, "R4");
    check(sync_ok, 1'b1, "R4 sixteen errors hold");
    errs(1, "R4");
    check(sync_ok, 1'b0, "R4 seventeenth error");

    // R7: restart needs four new commas
    commas(3, "R7");
    check(sync_ok, 1'b0, "R7 three commas after loss");
    commas(1, "R7");
    check(sync_ok, 1'b1, "R7 relock");

    // R5: one good run forgives one error
    errs(16, "R5");
    goods(16, "R5");
    errs(1, "R5");
    check(sync_ok, 1'b1, "R5 forgiven error");
    errs(1, "R5");
    check(sync_ok, 1'b0, "R5 limit reached");

    // R5: error breaks the good run
    commas(4, "R5");
    errs(16, "R5");
    goods(15, "R5");
    errs(1, "R5");
    check(sync_ok, 1'b0, "R5 run broken by error");

    // R6: no credit below zero
    commas(4, "R6");
    goods(48, "R6");
    errs(16, "R6");
    check(sync_ok, 1'b1, "R6 sixteen after credit");
    errs(1, "R6");
    check(sync_ok, 1'b0, "R6 no negative level");

    // R8: invalid cycles ignored while hunting and while locked
    commas(2, "R8");
    for (int i = 0; i < 5; i++) step(1'b0, K_N, 1'b1, "R8 idle hunt");
    commas(1, "R8");
    check(sync_ok, 1'b0, "R8 idle did not count comma");
    commas(1, "R8");
    check(sync_ok, 1'b1, "R8 idle did not clear count");
    errs(16, "R8");
    for (int i = 0; i < 10; i++) step(1'b0, DATA, 1'b1, "R8 idle locked");
    check(sync_ok, 1'b1, "R8 idle error ignored");
    errs(1, "R8");
    check(sync_ok, 1'b0, "R8 loss on real error");

    // random mix against the model
    for (int i = 0; i < 6000; i++) begin
      logic       v;
      logic [9:0] cg;
      logic       e;
      int         ep;
      ep = ((i / 500) % 2) ? 35 : 6;
      v  = ($urandom_range(99) < 85);
      if ($urandom_range(99) < 40) cg = $urandom_range(1) ? K_P : K_N;
      else cg = 10'($urandom_range(1023));
      e  = ($urandom_range(99) < ep);
      step(v, cg, e, "R2/R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule